// File: doc/BRIEF.md
# Clustered Bundle Fetch Distributor

This block sits between instruction memory and a row of two-issue execution clusters. Each cycle it presents a fetch address and takes back a fetch line made of one 64-bit cluster word per cluster. Each cluster word carries two 32-bit operations. The block scans the stop bits to find where the current bundle ends. It hands each cluster word that belongs to the bundle to its cluster with a valid flag, and it computes the address of the next bundle from the bundle's length in cluster words.

A width-control bundle is recognised by a partial decode. Such a bundle has an opcode of 6'h3E in its first operation, and every other operation in it is a NOP. It is never issued. Instead it updates a cluster gating vector and pulses a strobe for the clock controller. There is no prediction. A resolved taken branch arrives on the redirect inputs. It squashes whatever is being fetched or presented that cycle, and fetch restarts at the target.

Operation layout, most significant bit first: stop [31], opcode [30:25], destination [24:20], source [19:15], a reserved bit [14], and immediate [13:0].

Top module: `fetch_distributor`

## Requirements
- R1: While rst_ni is low and after it rises, with no bundle accepted yet, all cluster valid flags are 0, the strobe is 0, the gating vector is 0, and the fetch address equals the RESET_PC parameter.
- R2: The bundle length k is 1 plus the index of the first cluster word in which either operation has bit 31 set. If no cluster word has bit 31 set, k is the cluster count. An issued bundle raises the valid flags of clusters 0..k-1 only.
- R3: Cluster word w (bundle_i bits [64w+63:64w]) of an accepted, issued bundle appears on cl_op_o bits [64w+63:64w] in the cycle after acceptance.
- R4: Each accepted bundle, shutoff bundles included, moves the fetch address forward by 8*k bytes at the next clock edge.
- R5: A bundle is a shutoff bundle when its first operation (word 0, bits [31:0]) has opcode 6'h3E and every other operation within its k words has opcode 6'h00. On acceptance of a shutoff bundle, shutoff_stb_o is 1 for one cycle and no valid flag is raised. shutoff_o becomes immediate bits [N-1:0] with bit 0 forced to 0, so cluster 0 always stays on. A clear bit re-enables its cluster.
- R6: shutoff_o keeps its value until the next shutoff bundle is accepted. A bundle whose first opcode is 6'h3E but which has another non-NOP operation is issued as an ordinary bundle and raises no strobe.
- R7: While redirect_i is 1, cl_valid_o is 0 in that same cycle. The fetch address equals redirect_target_i after the edge. The bundle offered during the redirect cycle is discarded: no valid flags, no strobe, and no change to shutoff_o.
- R8: While bundle_valid_i is 0 and redirect_i is 0, the fetch address holds, and no valid flag or strobe is raised at the next edge.
- R9: Alongside an issued bundle, link_addr_o gives the address of the bundle that follows it (fetch address + 8*k). A jump uses this value as its return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bundle_i | input | 64*N_CLUSTERS | Fetch line read at fetch_addr_o |
| bundle_valid_i | input | 1 | Fetch line is present this cycle |
| redirect_i | input | 1 | Resolved taken branch |
| redirect_target_i | input | ADDR_W | Branch target address |
| fetch_addr_o | output | ADDR_W | Address of the bundle being fetched |
| cl_op_o | output | 64*N_CLUSTERS | Operation pair for each cluster |
| cl_valid_o | output | N_CLUSTERS | Valid flag for each cluster |
| link_addr_o | output | ADDR_W | Address following the issued bundle |
| shutoff_o | output | N_CLUSTERS | Cluster gating vector, set bit turns the cluster off |
| shutoff_stb_o | output | 1 | One-cycle pulse when a new gating vector is loaded |

## Verification
The hardest situation to reach is a redirect that lands while the presented bundle still has valid flags and the fetch line on the inputs is itself a shutoff bundle. That combination exercises the same-cycle flush of the outputs and the discard of a gating update on one edge. The stimulus first issues an ordinary bundle. On the next cycle it raises the redirect together with a shutoff line, and it samples the valid flags before the edge. Another tricky case is a shutoff opcode whose bundle has one non-NOP operation. It is placed directly after a real shutoff bundle, so a wrong decode would show up as a changed gating vector.

// File: rtl/fetch_dist_pkg.sv
package fetch_dist_pkg;
  localparam int OP_W    = 32;
  localparam int CWORD_W = 2 * OP_W;
  localparam logic [5:0] OPC_NOP     = 6'h00;
  localparam logic [5:0] OPC_SHUTOFF = 6'h3E;

  typedef struct packed {
    logic        stop;
    logic [5:0]  opc;
    logic [4:0]  rd;
    logic [4:0]  rs;
    logic        rsvd;
    logic [13:0] imm;
  } op_t;
endpackage

// File: rtl/fd_len_scan.sv
module fd_len_scan
  import fetch_dist_pkg::*;
#(
  parameter int N_CLUSTERS = 4,
  localparam int LEN_W = $clog2(N_CLUSTERS + 1)
) (
  input  logic [N_CLUSTERS*CWORD_W-1:0] line_i,
  output logic [N_CLUSTERS-1:0]         keep_o,
  output logic [LEN_W-1:0]              len_o
);
  logic [N_CLUSTERS-1:0] stop_w;

  for (genvar w = 0; w < N_CLUSTERS; w++) begin : g_stop
    assign stop_w[w] = line_i[w*CWORD_W + OP_W - 1] | line_i[w*CWORD_W + CWORD_W - 1];
  end

  // serial scan: words up to and including the first stop belong to the bundle
  always_comb begin
    logic seen;
    seen   = 1'b0;
    keep_o = '0;
    len_o  = '0;
    for (int w = 0; w < N_CLUSTERS; w++) begin
      if (!seen) begin
        keep_o[w] = 1'b1;
        len_o     = len_o + LEN_W'(1);
      end
      if (stop_w[w]) seen = 1'b1;
    end
  end
endmodule

// File: rtl/fd_shutoff_det.sv
module fd_shutoff_det
  import fetch_dist_pkg::*;
#(
  parameter int N_CLUSTERS = 4
) (
  input  logic [N_CLUSTERS*CWORD_W-1:0] line_i,
  input  logic [N_CLUSTERS-1:0]         keep_i,
  output logic                          hit_o,
  output logic [N_CLUSTERS-1:0]         vec_o
);
  localparam int N_OPS = 2 * N_CLUSTERS;

  logic [N_OPS-1:0] quiet;
  op_t              lead;

  assign lead = op_t'(line_i[OP_W-1:0]);

  for (genvar j = 0; j < N_OPS; j++) begin : g_op
    op_t o;
    assign o = op_t'(line_i[j*OP_W +: OP_W]);
    if (j == 0) begin : g_lead
      assign quiet[j] = 1'b1;
    end else begin : g_rest
      assign quiet[j] = !keep_i[j/2] || (o.opc == OPC_NOP);
    end
  end

  assign hit_o = (lead.opc == OPC_SHUTOFF) && (&quiet);
  assign vec_o = {lead.imm[N_CLUSTERS-1:1], 1'b0};
endmodule

// File: rtl/fetch_distributor.sv
module fetch_distributor
  import fetch_dist_pkg::*;
#(
  parameter int              N_CLUSTERS = 4,
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CLUSTERS*CWORD_W-1:0] bundle_i,
  input  logic                          bundle_valid_i,
  input  logic                          redirect_i,
  input  logic [ADDR_W-1:0]             redirect_target_i,
  output logic [ADDR_W-1:0]             fetch_addr_o,
  output logic [N_CLUSTERS*CWORD_W-1:0] cl_op_o,
  output logic [N_CLUSTERS-1:0]         cl_valid_o,
  output logic [ADDR_W-1:0]             link_addr_o,
  output logic [N_CLUSTERS-1:0]         shutoff_o,
  output logic                          shutoff_stb_o
);
  localparam int LEN_W = $clog2(N_CLUSTERS + 1);
  localparam int CW_SHIFT = $clog2(CWORD_W / 8);

  logic [N_CLUSTERS-1:0] keep, shut_vec, valid_q, shut_q;
  logic [LEN_W-1:0]      len;
  logic                  shut_hit, accept, issue, stb_q;
  logic [ADDR_W-1:0]     pc_q, link_q, next_pc;

  fd_len_scan #(.N_CLUSTERS(N_CLUSTERS)) i_len (
    .line_i(bundle_i), .keep_o(keep), .len_o(len)
  );

  fd_shutoff_det #(.N_CLUSTERS(N_CLUSTERS)) i_shut (
    .line_i(bundle_i), .keep_i(keep), .hit_o(shut_hit), .vec_o(shut_vec)
  );

  assign accept  = bundle_valid_i && !redirect_i;
  assign issue   = accept && !shut_hit;
  assign next_pc = pc_q + (ADDR_W'(len) << CW_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      link_q  <= RESET_PC;
      valid_q <= '0;
      shut_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q   <= accept && shut_hit;
      valid_q <= issue ? keep : '0;
      if (issue) link_q <= next_pc;
      if (accept && shut_hit) shut_q <= shut_vec;
      if (redirect_i)  pc_q <= redirect_target_i;
      else if (accept) pc_q <= next_pc;
    end
  end

  // per-cluster operand registers load only for words inside the bundle
  for (genvar w = 0; w < N_CLUSTERS; w++) begin : g_cl
    logic [CWORD_W-1:0] op_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                op_q <= '0;
      else if (issue && keep[w])  op_q <= bundle_i[w*CWORD_W +: CWORD_W];
    end
    assign cl_op_o[w*CWORD_W +: CWORD_W] = op_q;
  end

  // a taken branch squashes the presented bundle in the same cycle
  assign cl_valid_o    = valid_q & {N_CLUSTERS{!redirect_i}};
  assign fetch_addr_o  = pc_q;
  assign link_addr_o   = link_q;
  assign shutoff_o     = shut_q;
  assign shutoff_stb_o = stb_q;

  a_r7_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> fetch_addr_o == $past(redirect_target_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bundle_valid_i && !redirect_i) |=> $stable(fetch_addr_o));

  a_r5_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutoff_stb_o |-> valid_q == '0);

  a_r2_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_q + N_CLUSTERS'(1)) & valid_q) == '0);

  a_r9_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_q) |-> link_addr_o == fetch_addr_o);

  a_r5_keep_c0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutoff_stb_o |-> !shutoff_o[0]);
endmodule

// File: tb/test_fetch_distributor.sv
module test_fetch_distributor;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int CLK_PERIOD = 10;
  localparam int LW = N * 64;
  localparam logic [AW-1:0] RST_PC = 32'h0000_1000;

  // {stop word (4 = none), stop on second op, kind 0 normal/1 shutoff/2 bad shutoff, seed}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {3'd4, 1'b0, 2'd0, 8'h11},
    {3'd0, 1'b0, 2'd0, 8'h22},
    {3'd1, 1'b1, 2'd0, 8'h33},
    {3'd2, 1'b0, 2'd0, 8'h44},
    {3'd0, 1'b0, 2'd1, 8'h0B},
    {3'd3, 1'b0, 2'd1, 8'h05},
    {3'd1, 1'b1, 2'd2, 8'h0F},
    {3'd0, 1'b0, 2'd1, 8'h00},
    {3'd3, 1'b1, 2'd0, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [LW-1:0] bundle_i = '0;
  logic bundle_valid_i = 1'b0;
  logic redirect_i = 1'b0;
  logic [AW-1:0] redirect_target_i = '0;
  logic [AW-1:0] fetch_addr_o, link_addr_o;
  logic [LW-1:0] cl_op_o;
  logic [N-1:0] cl_valid_o, shutoff_o;
  logic shutoff_stb_o;

  int checks = 0;
  int errors = 0;

  fetch_distributor #(.N_CLUSTERS(N), .ADDR_W(AW), .RESET_PC(RST_PC)) i_fetch_distributor (
    .clk_i(clk), .rst_ni, .bundle_i, .bundle_valid_i, .redirect_i, .redirect_target_i,
    .fetch_addr_o, .cl_op_o, .cl_valid_o, .link_addr_o, .shutoff_o, .shutoff_stb_o
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_op(logic stop, logic [5:0] opc, logic [4:0] rd,
                                        logic [4:0] rs, logic [13:0] imm);
    return {stop, opc, rd, rs, 1'b0, imm};
  endfunction

  function automatic logic [LW-1:0] build(logic [13:0] v);
    logic [2:0] sw = v[13:11];
    logic s1 = v[10];
    logic [1:0] kind = v[9:8];
    logic [7:0] sd = v[7:0];
    logic [LW-1:0] b = '0;
    for (int w = 0; w < N; w++) begin
      logic [5:0] o0, o1;
      logic [13:0] i0;
      o0 = (kind == 2'd0) ? 6'(6'h01 + w) : ((w == 0) ? 6'h3E : 6'h00);
      o1 = (kind == 2'd0) ? 6'(6'h08 + w) : ((kind == 2'd2 && w == 0) ? 6'h05 : 6'h00);
      i0 = (kind != 2'd0 && w == 0) ? {6'h00, sd} : {sd, 6'(w)};
      b[w*64 +: 32]      = mk_op(sw == 3'(w) && !s1, o0, 5'(sd) ^ 5'(w), 5'(w + 3), i0);
      b[w*64 + 32 +: 32] = mk_op(sw == 3'(w) && s1, o1, 5'(w + 9), 5'(sd[7:3]), 14'(sd + 8'(w)));
    end
    return b;
  endfunction

  function automatic logic [LW-1:0] mask_words(logic [LW-1:0] b, logic [N-1:0] m);
    logic [LW-1:0] r = '0;
    for (int w = 0; w < N; w++) if (m[w]) r[w*64 +: 64] = b[w*64 +: 64];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] exp_pc;
    logic [N-1:0]  exp_shut;
    logic [LW-1:0] b;

    repeat (2) @(negedge clk);
    chk("R1", "valid in reset", LW'(cl_valid_o), '0);
    chk("R1", "addr in reset", LW'(fetch_addr_o), LW'(RST_PC));
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", LW'(cl_valid_o), '0);
    chk("R1", "strobe after reset", LW'(shutoff_stb_o), '0);
    chk("R1", "vector after reset", LW'(shutoff_o), '0);
    chk("R1", "addr after reset", LW'(fetch_addr_o), LW'(RST_PC));
    exp_pc = RST_PC;
    exp_shut = '0;

    for (int i = 0; i < NV; i++) begin
      int k;
      logic [1:0] kind;
      logic [N-1:0] m;
      k = (VEC[i][13:11] == 3'd4) ? N : int'(VEC[i][13:11]) + 1;
      kind = VEC[i][9:8];
      m = (kind == 2'd1) ? '0 : N'((1 << k) - 1);
      b = build(VEC[i]);
      bundle_i = b;
      bundle_valid_i = 1'b1;
      @(negedge clk);
      exp_pc = exp_pc + AW'(8 * k);
      if (kind == 2'd1) exp_shut = {VEC[i][N-1:1], 1'b0};
      chk(kind == 2'd1 ? "R5" : "R2", "valid mask", LW'(cl_valid_o), LW'(m));
      chk(kind == 2'd2 ? "R6" : "R5", "strobe", LW'(shutoff_stb_o), LW'(kind == 2'd1));
      chk(kind == 2'd2 ? "R6" : "R5", "gating vector", LW'(shutoff_o), LW'(exp_shut));
      chk("R4", "next fetch addr", LW'(fetch_addr_o), LW'(exp_pc));
      if (m != '0) begin
        chk("R3", "routed ops", mask_words(cl_op_o, m), mask_words(b, m));
        chk("R9", "link addr", LW'(link_addr_o), LW'(exp_pc));
      end
    end

    // R8 stall
    bundle_valid_i = 1'b0;
    bundle_i = build(VEC[0]);
    @(negedge clk);
    chk("R8", "stall valid", LW'(cl_valid_o), '0);
    chk("R8", "stall strobe", LW'(shutoff_stb_o), '0);
    chk("R8", "stall addr", LW'(fetch_addr_o), LW'(exp_pc));

    // issue a 2-word bundle, then redirect with a shutoff line on the inputs
    bundle_i = build({3'd1, 1'b0, 2'd0, 8'h77});
    bundle_valid_i = 1'b1;
    @(negedge clk);
    exp_pc = exp_pc + AW'(16);
    chk("R2", "pre-flush valid", LW'(cl_valid_o), LW'(4'b0011));
    bundle_i = build({3'd0, 1'b0, 2'd1, 8'h0E});
    redirect_i = 1'b1;
    redirect_target_i = 32'h0000_8000;
    #1;
    chk("R7", "same-cycle flush", LW'(cl_valid_o), '0);
    @(negedge clk);
    chk("R7", "target addr", LW'(fetch_addr_o), LW'(32'h0000_8000));
    chk("R7", "discarded valid", LW'(cl_valid_o), '0);
    chk("R7", "discarded strobe", LW'(shutoff_stb_o), '0);
    chk("R7", "vector unchanged", LW'(shutoff_o), LW'(exp_shut));
    redirect_i = 1'b0;
    b = build({3'd4, 1'b0, 2'd0, 8'h3C});
    bundle_i = b;
    @(negedge clk);
    chk("R7", "target bundle valid", LW'(cl_valid_o), LW'(4'b1111));
    chk("R3", "target bundle ops", cl_op_o, b);
    chk("R9", "target link", LW'(link_addr_o), LW'(32'h0000_8020));
    bundle_valid_i = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule